// File: doc/BRIEF.md
# Paired-Page Variable-Size Translation Buffer

This block is a fully associative address translation buffer. It turns a virtual address and an address-space identifier into a physical address. Each of its entries covers two neighbouring virtual pages, an even page and an odd page, and points each of them at its own physical frame. Every entry carries its own page size, which may be any power of four from 4 KB up to 16 MB.

The lookup path is purely combinational. A requester presents a virtual address and an identifier. In the same cycle it gets back four things: whether some entry matched, whether the chosen page is valid, the translated physical address, and a flag that reports an ambiguous translation where several entries claim the address. Software-side logic loads entries one at a time through an indexed write port, and each write lands on the next rising clock edge. Miss handling and victim selection belong to the surrounding logic.

Top module: `pair_tlb`

## Requirements
- R1: While reset is asserted and after it is released, until the first write, no lookup matches: lk_match, lk_valid, lk_hit and lk_multi are 0.
- R2: A write with wr_en high updates entry wr_idx on the next rising clock edge. A lookup in the same cycle as the write still sees the entry's old contents.
- R3: Size code s (0..6) gives a page of 4 KB × 4^s. The tag compare then uses only virtual address bits [43:13+2s]. Codes 7 and above act as code 6 (16 MB).
- R4: Virtual address bit 12+2s picks the frame: 0 selects frame 0 (the even page) and 1 selects frame 1 (the odd page).
- R5: On a match, lk_pa[39:12+2s] holds the selected frame number bits [27:2s]. lk_pa[11+2s:0] holds lk_va[11+2s:0].
- R6: An entry matches only if its stored identifier equals lk_asid or its global bit is set.
- R7: An entry matches only if at least one of its two valid bits is set. lk_valid reports the valid bit of the selected page, and lk_hit is high only when lk_match and lk_valid are both high.
- R8: When no entry matches, lk_pa is 0 and lk_valid and lk_hit are 0.
- R9: When two or more entries match, lk_multi is 1 and the entry with the lowest index supplies lk_pa and lk_valid. When one or no entry matches, lk_multi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 6 | Index of the entry to load |
| wr_vtag | input | 31 | Virtual pair tag, virtual address bits [43:13] |
| wr_size | input | 3 | Page size code |
| wr_asid | input | 8 | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pfn0 | input | 28 | Frame number of the even page (4 KB units) |
| wr_v0 | input | 1 | Even page valid |
| wr_pfn1 | input | 28 | Frame number of the odd page (4 KB units) |
| wr_v1 | input | 1 | Odd page valid |
| lk_va | input | 44 | Virtual address to translate |
| lk_asid | input | 8 | Identifier of the requester |
| lk_match | output | 1 | Some entry matched tag, identifier and liveness |
| lk_valid | output | 1 | Selected page's valid bit |
| lk_hit | output | 1 | Usable translation |
| lk_pa | output | 40 | Translated physical address |
| lk_multi | output | 1 | More than one entry matched |

## Verification
A write and a lookup can fall in the same cycle, and that lookup may target the entry being loaded. The bench provokes this in a single cycle. It drives wr_en together with a lookup of the new tag. Before the clock edge it expects a miss, because the lookup still sees the old, empty entry. After the edge, with the inputs held, it expects a hit with the new frame. All other lookups are judged against a bench-side table, filled from the writes and evaluated arithmetically per requirement, across every page size.

// File: rtl/pair_tlb.sv
module pair_tlb #(
  parameter int ENTRIES  = 64,
  parameter int VA_W     = 44,
  parameter int PA_W     = 40,
  parameter int ASID_W   = 8,
  parameter int BASE_OFF = 12,
  parameter int NSIZE    = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(ENTRIES)-1:0]        wr_idx,
  input  logic [VA_W-BASE_OFF-2:0]          wr_vtag,
  input  logic [$clog2(NSIZE)-1:0]          wr_size,
  input  logic [ASID_W-1:0]                 wr_asid,
  input  logic                              wr_global,
  input  logic [PA_W-BASE_OFF-1:0]          wr_pfn0,
  input  logic                              wr_v0,
  input  logic [PA_W-BASE_OFF-1:0]          wr_pfn1,
  input  logic                              wr_v1,
  input  logic [VA_W-1:0]                   lk_va,
  input  logic [ASID_W-1:0]                 lk_asid,
  output logic                              lk_match,
  output logic                              lk_valid,
  output logic                              lk_hit,
  output logic [PA_W-1:0]                   lk_pa,
  output logic                              lk_multi
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = VA_W - BASE_OFF - 1;
  localparam int PFN_W = PA_W - BASE_OFF;
  localparam int SZ_W  = $clog2(NSIZE);

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [SZ_W-1:0]   sz_q   [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn0_q [ENTRIES];
  logic [PFN_W-1:0]  pfn1_q [ENTRIES];
  logic [ENTRIES-1:0] glb_q, v0_q, v1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        sz_q[i]   <= '0;
        asid_q[i] <= '0;
        pfn0_q[i] <= '0;
        pfn1_q[i] <= '0;
      end
      glb_q <= '0;
      v0_q  <= '0;
      v1_q  <= '0;
    end else if (wr_en) begin
      tag_q[wr_idx]  <= wr_vtag;
      sz_q[wr_idx]   <= wr_size;
      asid_q[wr_idx] <= wr_asid;
      pfn0_q[wr_idx] <= wr_pfn0;
      pfn1_q[wr_idx] <= wr_pfn1;
      glb_q[wr_idx]  <= wr_global;
      v0_q[wr_idx]   <= wr_v0;
      v1_q[wr_idx]   <= wr_v1;
    end
  end

  logic [ENTRIES-1:0] ent_hit;
  logic [ENTRIES-1:0] ent_valid;
  logic [PA_W-1:0]    ent_pa [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [TAG_W-1:0] care;
    logic             odd;
    logic [PA_W-1:0]  keep;
    logic [PFN_W-1:0] pfn;
    int unsigned      sh;

    always_comb begin
      sh = (int'(sz_q[g]) > NSIZE - 1) ? 2 * (NSIZE - 1) : 2 * int'(sz_q[g]);
      for (int j = 0; j < TAG_W; j++) care[j] = (j >= int'(sh));
      odd  = lk_va[BASE_OFF + sh];
      keep = (PA_W'(1) << (BASE_OFF + sh)) - PA_W'(1);
      pfn  = odd ? pfn1_q[g] : pfn0_q[g];
    end

    assign ent_hit[g]   = (((lk_va[VA_W-1:BASE_OFF+1] ^ tag_q[g]) & care) == '0)
                          && (glb_q[g] || (asid_q[g] == lk_asid))
                          && (v0_q[g] || v1_q[g]);
    assign ent_valid[g] = odd ? v1_q[g] : v0_q[g];
    assign ent_pa[g]    = ({pfn, {BASE_OFF{1'b0}}} & ~keep) | (lk_va[PA_W-1:0] & keep);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ent_hit[i]) sel = IDX_W'(i);
  end

  assign lk_match = |ent_hit;
  assign lk_multi = $countones(ent_hit) > 1;
  assign lk_valid = lk_match && ent_valid[sel];
  assign lk_hit   = lk_match && ent_valid[sel];
  assign lk_pa    = lk_match ? ent_pa[sel] : '0;

  // R9
  multi_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_match);

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_match |-> (lk_pa == '0 && !lk_valid && !lk_hit));

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_match |-> lk_pa[BASE_OFF-1:0] == lk_va[BASE_OFF-1:0]);

  // R2
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(lk_va) && $stable(lk_asid))
      |-> ($stable(lk_pa) && $stable(lk_hit) && $stable(lk_multi)));
endmodule

// File: tb/pair_tlb_tb_top.sv
module pair_tlb_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_en, wr_global, wr_v0, wr_v1;
  logic [5:0]  wr_idx;
  logic [30:0] wr_vtag;
  logic [2:0]  wr_size;
  logic [7:0]  wr_asid, lk_asid;
  logic [27:0] wr_pfn0, wr_pfn1;
  logic [43:0] lk_va;
  logic        lk_match, lk_valid, lk_hit, lk_multi;
  logic [39:0] lk_pa;

  pair_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vtag(wr_vtag),
    .wr_size(wr_size), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_pfn1(wr_pfn1), .wr_v1(wr_v1),
    .lk_va(lk_va), .lk_asid(lk_asid), .lk_match(lk_match), .lk_valid(lk_valid),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_multi(lk_multi));

  longint m_tag [64];
  int     m_sz  [64];
  int     m_asid[64];
  bit     m_g   [64];
  longint m_p0  [64];
  longint m_p1  [64];
  bit     m_v0  [64];
  bit     m_v1  [64];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input longint va, input int asid,
                       output bit m, output bit v, output bit h, output bit mul, output longint pa);
    int cnt = 0;
    m = 0; v = 0; h = 0; mul = 0; pa = 0;
    for (int i = 0; i < 64; i++) begin
      int s = (m_sz[i] > 6) ? 6 : m_sz[i];
      int sh = 2 * s;
      longint vt = (va >> 13) & 64'h7fffffff;
      if (((vt >> sh) == (m_tag[i] >> sh)) && (m_g[i] || m_asid[i] == asid) && (m_v0[i] || m_v1[i])) begin
        cnt++;
        if (cnt == 1) begin
          bit odd = ((va >> (12 + sh)) & 1) != 0;
          longint pfn = odd ? m_p1[i] : m_p0[i];
          v  = odd ? m_v1[i] : m_v0[i];
          pa = ((pfn >> sh) << (12 + sh)) | (va & ((64'd1 << (12 + sh)) - 1));
        end
      end
    end
    m = cnt > 0;
    mul = cnt > 1;
    h = m && v;
  endtask

  task automatic compare(input string req);
    bit m, v, h, mul;
    longint pa;
    model(longint'(lk_va), int'(lk_asid), m, v, h, mul, pa);
    chk(req, "match", longint'(lk_match), longint'(m));
    chk(req, "valid", longint'(lk_valid), longint'(v));
    chk(req, "hit",   longint'(lk_hit),   longint'(h));
    chk(req, "pa",    longint'(lk_pa),    pa);
    chk(req, "multi", longint'(lk_multi), longint'(mul));
  endtask

  task automatic look(input longint va, input int asid, input string req);
    @(negedge clk);
    lk_va = va[43:0];
    lk_asid = asid[7:0];
    #1;
    compare(req);
  endtask

  task automatic commit(input int idx, input longint tag, input int sz, input int asid,
                        input bit g, input longint p0, input bit v0, input longint p1, input bit v1);
    m_tag[idx] = tag; m_sz[idx] = sz; m_asid[idx] = asid; m_g[idx] = g;
    m_p0[idx] = p0; m_v0[idx] = v0; m_p1[idx] = p1; m_v1[idx] = v1;
  endtask

  task automatic drive_wr(input int idx, input longint tag, input int sz, input int asid,
                          input bit g, input longint p0, input bit v0, input longint p1, input bit v1);
    wr_en = 1; wr_idx = idx[5:0]; wr_vtag = tag[30:0]; wr_size = sz[2:0];
    wr_asid = asid[7:0]; wr_global = g; wr_pfn0 = p0[27:0]; wr_v0 = v0;
    wr_pfn1 = p1[27:0]; wr_v1 = v1;
  endtask

  task automatic do_write(input int idx, input longint tag, input int sz, input int asid,
                          input bit g, input longint p0, input bit v0, input longint p1, input bit v1);
    @(negedge clk);
    drive_wr(idx, tag, sz, asid, g, p0, v0, p1, v1);
    @(posedge clk);
    commit(idx, tag, sz, asid, g, p0, v0, p1, v1);
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) commit(i, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_vtag = 0; wr_size = 0; wr_asid = 0;
    wr_global = 0; wr_pfn0 = 0; wr_v0 = 0; wr_pfn1 = 0; wr_v1 = 0;
    lk_va = 0; lk_asid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "match in reset", longint'(lk_match), 0);
    chk("R1", "hit in reset", longint'(lk_hit), 0);
    @(negedge clk);
    rst_n = 1;
    look(0, 0, "R1");
    look(44'hfff_ffff_ffff, 255, "R1");

    // per-size entries: index 2*s, identifier 3
    for (int s = 0; s < 7; s++) begin
      longint tag = longint'($urandom) & 64'h7fffffff;
      do_write(2 * s, tag, s, 3, 0, longint'($urandom) & 64'hfffffff, 1,
               longint'($urandom) & 64'hfffffff, 1);
      for (int k = 0; k < 24; k++) begin
        longint base = tag << 13;
        longint rnd  = {$urandom, $urandom};
        longint low  = rnd & ((64'd1 << (13 + 2 * s)) - 1);
        look(base | low, 3, "R5");
        look((base | low) ^ (64'd1 << (12 + 2 * s)), 3, "R4");
        look((base | low) ^ (64'd1 << (13 + 2 * s)), 3, "R3");
        look(base | low, 4, "R6");
      end
    end

    // global entry matches any identifier
    do_write(20, 64'h1234567, 1, 9, 1, 64'h0abcdef, 1, 64'h0fedcba, 1);
    for (int a = 0; a < 256; a += 17) look((64'h1234567 << 13) | 64'h5a5, a, "R6");

    // only the even page valid
    do_write(21, 64'h2222222, 0, 5, 0, 64'h0111111, 1, 64'h0333333, 0);
    look((64'h2222222 << 13) | 64'h010, 5, "R7");
    look((64'h2222222 << 13) | 64'h1010, 5, "R7");
    chk("R7", "odd invalid match", longint'(lk_match), 1);
    chk("R7", "odd invalid hit", longint'(lk_hit), 0);

    // both pages invalid: entry never matches
    do_write(22, 64'h3333333, 0, 5, 0, 64'h0444444, 0, 64'h0555555, 0);
    look((64'h3333333 << 13) | 64'h020, 5, "R7");
    look((64'h3333333 << 13) | 64'h1020, 5, "R8");

    // size codes above 6 behave as 16 MB
    do_write(23, 64'h7fff000, 7, 6, 0, 64'h0f00000, 1, 64'h0e00000, 1);
    look((64'h7fff000 << 13) | 64'h0_00ff_ffff, 6, "R3");
    look((64'h7fff000 << 13) | 64'h0_01ab_cdef, 6, "R3");

    // two entries claim the same pair: lowest index wins
    do_write(31, 64'h4444444, 0, 7, 0, 64'h0999999, 1, 64'h0888888, 1);
    do_write(30, 64'h4444444, 2, 7, 0, 64'h0777770, 1, 64'h0666660, 0);
    look((64'h4444444 << 13) | 64'h0ab, 7, "R9");
    chk("R9", "multi flag", longint'(lk_multi), 1);
    look((64'h4444444 << 13) | 64'h10ab, 7, "R9");

    // write and lookup in the same cycle
    @(negedge clk);
    drive_wr(40, 64'h5151515, 0, 0, 1, 64'h0c0ffee, 1, 64'h0beef00, 1);
    lk_va = 44'((64'h5151515 << 13) | 64'h123);
    lk_asid = 8'd1;
    #1;
    chk("R2", "hit before edge", longint'(lk_hit), 0);
    compare("R2");
    @(posedge clk);
    commit(40, 64'h5151515, 0, 0, 1, 64'h0c0ffee, 1, 64'h0beef00, 1);
    #1;
    chk("R2", "hit after edge", longint'(lk_hit), 1);
    compare("R2");
    @(negedge clk);
    wr_en = 0;

    // random traffic, including overwrites and duplicates
    for (int n = 0; n < 400; n++) begin
      int idx = $urandom_range(0, 63);
      int src = $urandom_range(0, 63);
      longint tag = ($urandom_range(0, 3) == 0) ? m_tag[src] : (longint'($urandom) & 64'h7fffffff);
      do_write(idx, tag, $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 1),
               longint'($urandom) & 64'hfffffff, $urandom_range(0, 1),
               longint'($urandom) & 64'hfffffff, $urandom_range(0, 1));
      for (int k = 0; k < 4; k++) begin
        int t = $urandom_range(0, 63);
        longint rnd = {$urandom, $urandom};
        look((m_tag[t] << 13) | (rnd & 64'hffffffff & ((64'd1 << (13 + 2 * $urandom_range(0, 6))) - 1)),
             $urandom_range(0, 3), "R9");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule